// File: doc/BRIEF.md
# Quad SPI command frame sequencer

This block runs one complete serial-flash transaction on a four-lane SPI bus. A command is handed over in a single cycle: opcode, address lane mode, 24-bit address, an optional alternate byte, a dummy-cycle count, the data lane mode and direction, a byte count and a clock prescaler. The block then lowers chip select and produces the serial clock from the system clock. It shifts out the frame phases in the fixed order instruction, address, alternate byte, dummy, data. Any phase after the instruction may be absent.

Write data is pulled from a byte-wide ready/valid stream and read data leaves as one-cycle pulses on a byte-wide stream. The four IO lanes are split into output, output-enable and input vectors so that the pad ring can build the bidirectional pins. Clock mode 0 is used and only single data rate is supported.

The controller is one state machine with the states IDLE, INSTR, ADDR, ALT, DUMMY, DATA and GUARD. The transitions are as follows:
- IDLE→INSTR on an accepted command.
- INSTR, ADDR, ALT and DUMMY each advance to the next present phase after their last clock cycle. The candidates are ADDR, ALT, DUMMY and DATA, and GUARD when none of these remains.
- DATA→DATA between bytes, and DATA→GUARD after the last byte.
- GUARD→IDLE once one full clock period with chip select high has passed.

Top module: `qspi_frame_seq`

## Requirements
- R1: A command is accepted only in IDLE when `cmd_valid` is high. In the next cycle `cs_n` is low and `busy` is high. `cmd_valid` while `busy` is high is ignored and starts no second frame.
- R2: The SCLK period is P+1 system cycles, where P is the prescaler captured with the command and a value of 0 counts as 1. The low part is at least as long as the high part. Each command may use a different prescaler.
- R3: The instruction phase is always present: 8 SCLK cycles on IO0, most significant bit first.
- R4: Address lane mode encoding: 1 sends the 24 bits on IO0 in 24 cycles, MSB first. 2 sends them as 6 nibbles on IO3..IO0, high nibble first. 0 and 3 omit the phase.
- R5: When enabled, the alternate byte takes 2 cycles on IO3..IO0, high nibble first.
- R6: A dummy count of N gives N SCLK cycles with all output enables low. N = 0 gives no dummy phase.
- R7: Write data (data mode 1 or 2, write flag high) is taken from the transmit stream when `tx_ready` and `tx_valid` are both high. It is sent MSB first on IO0 or high nibble first on IO3..IO0. SCLK is held low while no byte is offered.
- R8: In read data, the input is captured at each SCLK rising edge, from IO1 in mode 1 and from IO3..IO0 in mode 2, first bit most significant. Each completed byte gives one `rx_valid` pulse, and all output enables stay low.
- R9: A data mode of 0 or 3, or a byte count of 0, omits the data phase. The frame contains no SCLK cycles beyond its phases.
- R10: After the last cycle `cs_n` rises, SCLK stays low, and `busy` stays high for P+1 more cycles before IDLE is reached.
- R11: After reset: `cs_n`=1, `sclk`=0, `io_oe`=0, `busy`=0, `rx_valid`=0, `tx_ready`=0.
- R12: In single-lane output phases only IO0 is driven (`io_oe`=0001). In four-lane output phases all lanes are driven (1111). The output stays stable while SCLK is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command strobe |
| cmd_opcode | input | 8 | Instruction byte |
| cmd_addr_mode | input | 2 | Address lanes: 0 none, 1 one, 2 four, 3 none |
| cmd_addr | input | 24 | Address |
| cmd_alt_en | input | 1 | Alternate byte present |
| cmd_alt | input | 8 | Alternate byte |
| cmd_dummy | input | 5 | Dummy cycle count |
| cmd_data_mode | input | 2 | Data lanes: 0 none, 1 one, 2 four, 3 none |
| cmd_data_write | input | 1 | 1 write, 0 read |
| cmd_nbytes | input | 16 | Data byte count |
| cmd_presc | input | 8 | Clock prescaler |
| tx_valid | input | 1 | Write byte offered |
| tx_data | input | 8 | Write byte |
| tx_ready | output | 1 | Write byte taken this cycle |
| rx_valid | output | 1 | Read byte pulse |
| rx_data | output | 8 | Read byte |
| busy | output | 1 | Transaction in progress |
| sclk | output | 1 | Serial clock |
| cs_n | output | 1 | Chip select, active low |
| io_out | output | 4 | Lane output values |
| io_oe | output | 4 | Lane output enables |
| io_in | input | 4 | Lane input values |

## Verification
The scoreboard checks every SCLK rising edge of a frame, covering both lane enables and lane values. A single-lane read distinguishes IO1 capture from IO0 capture, because the two inputs carry opposite bits. A four-lane address, alternate byte and dummy read confirms the nibble order and the released bus. A single-lane address write with a starving transmit stream shows that the clock stalls instead of sending stale data. A four-lane write with a stray mid-frame command shows that commands are ignored while busy. Frames with only an instruction, or with reserved lane codes, show that skipped phases add no clock cycles. Prescalers 0 through 4 tell apart the period rule and the chip-select gap.

// File: rtl/qfs_pkg.sv
package qfs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_INSTR,
        ST_ADDR,
        ST_ALT,
        ST_DUMMY,
        ST_DATA,
        ST_GUARD
    } qfs_state_e;

    localparam logic [1:0] LN_NONE = 2'd0;
    localparam logic [1:0] LN_ONE  = 2'd1;
    localparam logic [1:0] LN_FOUR = 2'd2;

    function automatic logic ln_active(input logic [1:0] mode);
        return (mode == LN_ONE) || (mode == LN_FOUR);
    endfunction

endpackage

// File: rtl/qfs_sclk_gen.sv
module qfs_sclk_gen #(
    parameter int PRESC_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic [PRESC_W-1:0] presc,
    output logic               sclk,
    output logic               rise_tick,
    output logic               end_tick
);
    logic [PRESC_W-1:0] p_eff;
    logic [PRESC_W-1:0] cnt_q, cnt_d;
    logic [PRESC_W:0]   period, low_len;

    always_comb begin
        p_eff     = (presc == '0) ? PRESC_W'(1) : presc;
        period    = {1'b0, p_eff} + (PRESC_W+1)'(1);
        low_len   = period - (period >> 1);
        end_tick  = en && (cnt_q == p_eff);
        rise_tick = en && ({1'b0, cnt_q} == (low_len - (PRESC_W+1)'(1)));
        cnt_d     = (!en || end_tick) ? '0 : cnt_q + PRESC_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            sclk  <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            sclk  <= en && ({1'b0, cnt_d} >= low_len);
        end
    end

endmodule

// File: rtl/qfs_lane_io.sv
module qfs_lane_io (
    input  logic       drive_en,
    input  logic       quad,
    input  logic [3:0] sh_top,
    input  logic [7:0] rx_sh,
    input  logic [3:0] io_in,
    output logic [3:0] io_out,
    output logic [3:0] io_oe,
    output logic [7:0] rx_next
);
    always_comb begin
        if (!drive_en) begin
            io_out = 4'b0000;
            io_oe  = 4'b0000;
        end else if (quad) begin
            io_out = sh_top;
            io_oe  = 4'b1111;
        end else begin
            io_out = {3'b000, sh_top[3]};
            io_oe  = 4'b0001;
        end
        rx_next = quad ? {rx_sh[3:0], io_in} : {rx_sh[6:0], io_in[1]};
    end

endmodule

// File: rtl/qspi_frame_seq.sv
module qspi_frame_seq
    import qfs_pkg::*;
#(
    parameter int ADDR_W  = 24,
    parameter int DUMMY_W = 5,
    parameter int COUNT_W = 16,
    parameter int PRESC_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    input  logic [7:0]         cmd_opcode,
    input  logic [1:0]         cmd_addr_mode,
    input  logic [ADDR_W-1:0]  cmd_addr,
    input  logic               cmd_alt_en,
    input  logic [7:0]         cmd_alt,
    input  logic [DUMMY_W-1:0] cmd_dummy,
    input  logic [1:0]         cmd_data_mode,
    input  logic               cmd_data_write,
    input  logic [COUNT_W-1:0] cmd_nbytes,
    input  logic [PRESC_W-1:0] cmd_presc,
    input  logic               tx_valid,
    input  logic [7:0]         tx_data,
    output logic               tx_ready,
    output logic               rx_valid,
    output logic [7:0]         rx_data,
    output logic               busy,
    output logic               sclk,
    output logic               cs_n,
    output logic [3:0]         io_out,
    output logic [3:0]         io_oe,
    input  logic [3:0]         io_in
);
    localparam int OP_W  = 8;
    localparam int PAD_W = ADDR_W - OP_W;
    localparam int CYC_W = (DUMMY_W > $clog2(ADDR_W)) ? DUMMY_W : $clog2(ADDR_W);

    qfs_state_e state_q, state_d;

    logic [ADDR_W-1:0]  sh_q, addr_q;
    logic [CYC_W-1:0]   cyc_q, byte_cyc, addr_cyc;
    logic [COUNT_W-1:0] bytes_q;
    logic [PRESC_W-1:0] presc_q, gcnt_q, p_eff;
    logic [DUMMY_W-1:0] dummy_q;
    logic [7:0]         alt_q, rx_sh_q, rx_next;
    logic [1:0]         amode_q, dmode_q;
    logic               alt_en_q, write_q, need_q;
    logic               rise_tick, end_tick, last_cyc;
    logic               clk_en, drive_en, quad;
    qfs_state_e         nx_instr, nx_addr, nx_alt, nx_dummy;

    // Phase skipping chain: each phase hands over to the next one present.
    always_comb begin
        p_eff    = (presc_q == '0) ? PRESC_W'(1) : presc_q;
        last_cyc = end_tick && (cyc_q == '0);
        byte_cyc = (dmode_q == LN_FOUR) ? CYC_W'(1) : CYC_W'(7);
        addr_cyc = (amode_q == LN_FOUR) ? CYC_W'(ADDR_W/4 - 1) : CYC_W'(ADDR_W - 1);
        nx_dummy = (ln_active(dmode_q) && bytes_q != '0) ? ST_DATA : ST_GUARD;
        nx_alt   = (dummy_q != '0) ? ST_DUMMY : nx_dummy;
        nx_addr  = alt_en_q ? ST_ALT : nx_alt;
        nx_instr = ln_active(amode_q) ? ST_ADDR : nx_addr;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (cmd_valid) state_d = ST_INSTR;
            ST_INSTR: if (last_cyc) state_d = nx_instr;
            ST_ADDR:  if (last_cyc) state_d = nx_addr;
            ST_ALT:   if (last_cyc) state_d = nx_alt;
            ST_DUMMY: if (last_cyc) state_d = nx_dummy;
            ST_DATA:  if (last_cyc && bytes_q == COUNT_W'(1)) state_d = ST_GUARD;
            ST_GUARD: if (gcnt_q == '0) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Outputs decoded from the current state.
    always_comb begin
        cs_n     = (state_q == ST_IDLE) || (state_q == ST_GUARD);
        busy     = (state_q != ST_IDLE);
        tx_ready = (state_q == ST_DATA) && need_q;
        clk_en   = !cs_n && !need_q;
        drive_en = 1'b0;
        quad     = 1'b0;
        unique case (state_q)
            ST_INSTR: drive_en = 1'b1;
            ST_ADDR:  begin drive_en = 1'b1; quad = (amode_q == LN_FOUR); end
            ST_ALT:   begin drive_en = 1'b1; quad = 1'b1; end
            ST_DATA:  begin drive_en = write_q; quad = (dmode_q == LN_FOUR); end
            default:  ;
        endcase
    end

    // Datapath: command capture, shifting, counters, receive assembly.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0; addr_q <= '0; alt_q <= '0; dummy_q <= '0;
            cyc_q <= '0; bytes_q <= '0; presc_q <= '0; gcnt_q <= '0;
            amode_q <= LN_NONE; dmode_q <= LN_NONE;
            alt_en_q <= 1'b0; write_q <= 1'b0; need_q <= 1'b0;
            rx_sh_q <= '0; rx_data <= '0; rx_valid <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (state_q == ST_IDLE && cmd_valid) begin
                sh_q     <= {cmd_opcode, {PAD_W{1'b0}}};
                cyc_q    <= CYC_W'(OP_W - 1);
                addr_q   <= cmd_addr;
                alt_q    <= cmd_alt;
                dummy_q  <= cmd_dummy;
                amode_q  <= cmd_addr_mode;
                dmode_q  <= cmd_data_mode;
                alt_en_q <= cmd_alt_en;
                write_q  <= cmd_data_write;
                bytes_q  <= cmd_nbytes;
                presc_q  <= cmd_presc;
                need_q   <= 1'b0;
            end else if (end_tick) begin
                if (cyc_q != '0) begin
                    cyc_q <= cyc_q - CYC_W'(1);
                    sh_q  <= quad ? {sh_q[ADDR_W-5:0], 4'b0000} : {sh_q[ADDR_W-2:0], 1'b0};
                end else begin
                    unique case (state_d)
                        ST_ADDR:  begin sh_q <= addr_q; cyc_q <= addr_cyc; end
                        ST_ALT:   begin sh_q <= {alt_q, {PAD_W{1'b0}}}; cyc_q <= CYC_W'(1); end
                        ST_DUMMY: cyc_q <= CYC_W'(dummy_q) - CYC_W'(1);
                        ST_DATA: begin
                            cyc_q  <= byte_cyc;
                            need_q <= write_q;
                            if (state_q == ST_DATA) bytes_q <= bytes_q - COUNT_W'(1);
                        end
                        ST_GUARD: gcnt_q <= p_eff;
                        default:  ;
                    endcase
                end
            end else if (tx_ready && tx_valid) begin
                sh_q   <= {tx_data, {PAD_W{1'b0}}};
                need_q <= 1'b0;
            end else if (state_q == ST_GUARD && gcnt_q != '0) begin
                gcnt_q <= gcnt_q - PRESC_W'(1);
            end

            if (state_q == ST_DATA && !write_q && rise_tick) begin
                rx_sh_q <= rx_next;
                if (cyc_q == '0) begin
                    rx_data  <= rx_next;
                    rx_valid <= 1'b1;
                end
            end
        end
    end

    qfs_sclk_gen #(.PRESC_W(PRESC_W)) u_sclk (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (clk_en),
        .presc     (presc_q),
        .sclk      (sclk),
        .rise_tick (rise_tick),
        .end_tick  (end_tick)
    );

    qfs_lane_io u_lanes (
        .drive_en (drive_en),
        .quad     (quad),
        .sh_top   (sh_q[ADDR_W-1 -: 4]),
        .rx_sh    (rx_sh_q),
        .io_in    (io_in),
        .io_out   (io_out),
        .io_oe    (io_oe),
        .rx_next  (rx_next)
    );

endmodule

// File: rtl/qfs_frame_checker.sv
module qfs_frame_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_valid,
    input logic       busy,
    input logic       cs_n,
    input logic       sclk,
    input logic       rx_valid,
    input logic [3:0] io_out,
    input logic [3:0] io_oe
);
    p_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !busy |=> busy && !cs_n);

    p_frame_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |-> busy);

    p_sclk_idle_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);

    p_cs_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |=> cs_n);

    p_oe_shape_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (io_oe == 4'b0000) || (io_oe == 4'b0001) || (io_oe == 4'b1111));

    p_out_stable_high_r12: assert property (@(posedge clk) disable iff (!rst_n)
        sclk && $past(sclk) |-> $stable(io_out));

    p_rx_in_frame_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> !cs_n && io_oe == 4'b0000);

endmodule

bind qspi_frame_seq qfs_frame_checker u_frame_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .busy      (busy),
    .cs_n      (cs_n),
    .sclk      (sclk),
    .rx_valid  (rx_valid),
    .io_out    (io_out),
    .io_oe     (io_oe)
);

// File: tb/test_qspi_frame_seq.sv
module test_qspi_frame_seq;
    localparam int CLK_NS = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [7:0]  cmd_opcode = '0;
    logic [1:0]  cmd_addr_mode = '0;
    logic [23:0] cmd_addr = '0;
    logic        cmd_alt_en = 1'b0;
    logic [7:0]  cmd_alt = '0;
    logic [4:0]  cmd_dummy = '0;
    logic [1:0]  cmd_data_mode = '0;
    logic        cmd_data_write = 1'b0;
    logic [15:0] cmd_nbytes = '0;
    logic [7:0]  cmd_presc = '0;
    logic        tx_valid = 1'b0;
    logic [7:0]  tx_data = '0;
    logic        tx_ready, rx_valid, busy, sclk, cs_n;
    logic [7:0]  rx_data;
    logic [3:0]  io_out, io_oe, io_in;

    logic [11:0] exp_q[$];
    logic [7:0]  rx_exp_q[$];
    logic [7:0]  tx_q[$];
    logic [3:0]  drive_arr [0:511];
    int          rise_cnt = 0;
    int          frames = 0;
    int          n_chk = 0;
    int          n_bad = 0;
    int          cur_p = 1;
    int          tx_gap = 0;
    bit          per_en = 1'b0;
    time         last_t = 0;
    bit          have_last = 1'b0;

    always #(CLK_NS/2) clk = ~clk;

    assign io_in = drive_arr[rise_cnt[8:0]];

    qspi_frame_seq i_qspi_frame_seq (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_opcode(cmd_opcode),
        .cmd_addr_mode(cmd_addr_mode), .cmd_addr(cmd_addr), .cmd_alt_en(cmd_alt_en),
        .cmd_alt(cmd_alt), .cmd_dummy(cmd_dummy), .cmd_data_mode(cmd_data_mode),
        .cmd_data_write(cmd_data_write), .cmd_nbytes(cmd_nbytes), .cmd_presc(cmd_presc),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready), .rx_valid(rx_valid),
        .rx_data(rx_data), .busy(busy), .sclk(sclk), .cs_n(cs_n), .io_out(io_out),
        .io_oe(io_oe), .io_in(io_in)
    );

    task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", rq, act, exp, $time);
        end
    endtask

    task automatic push(input int tag, input logic [3:0] oe, input logic [3:0] v);
        exp_q.push_back({tag[3:0], oe, v});
    endtask

    // Monitor: one expected lane entry per SCLK rising edge; frame start resets the index.
    always @(posedge sclk or negedge cs_n) begin
        if (!cs_n && !sclk) begin
            rise_cnt  = 0;
            have_last = 1'b0;
            frames++;
        end else if (sclk) begin
            #1;
            if (exp_q.size() == 0) begin
                check("R9 extra SCLK cycle", 32'd1, 32'd0);
            end else begin
                logic [11:0] e;
                e = exp_q.pop_front();
                check($sformatf("R%0d lane enables", e[11:8]), {28'd0, io_oe}, {28'd0, e[7:4]});
                check($sformatf("R%0d lane values", e[11:8]), {28'd0, io_out & e[7:4]},
                      {28'd0, e[3:0] & e[7:4]});
            end
            if (per_en && have_last)
                check("R2 SCLK period", 32'(($time - last_t) / CLK_NS), 32'(cur_p + 1));
            last_t    = $time;
            have_last = 1'b1;
            rise_cnt  = rise_cnt + 1;
        end
    end

    // Read byte monitor (R8).
    always @(negedge clk) begin
        if (rst_n && rx_valid) begin
            if (rx_exp_q.size() == 0) check("R8 unexpected read byte", 32'd1, 32'd0);
            else check("R8 read byte", {24'd0, rx_data}, {24'd0, rx_exp_q.pop_front()});
        end
    end

    // Chip-select gap monitor (R10).
    always @(posedge cs_n) begin
        if (rst_n) begin
            int g;
            g = 0;
            @(negedge clk);
            while (busy) begin
                g++;
                @(negedge clk);
            end
            check("R10 busy cycles after cs_n rise", 32'(g), 32'(cur_p + 1));
        end
    end

    // Transmit stream source with optional gaps (R7).
    always @(negedge clk) begin
        static bit took = 1'b0;
        static int hold = 0;
        if (took) begin
            void'(tx_q.pop_front());
            hold = tx_gap;
        end
        if (hold > 0) begin
            hold--;
            tx_valid = 1'b0;
        end else if (tx_q.size() > 0) begin
            tx_valid = 1'b1;
            tx_data  = tx_q[0];
        end else begin
            tx_valid = 1'b0;
        end
        took = tx_valid && tx_ready;
    end

    task automatic run(input logic [7:0] op, input logic [7:0] p, input logic [1:0] am,
                       input logic [23:0] ad, input logic ae, input logic [7:0] al,
                       input logic [4:0] dm, input logic [1:0] md, input logic wr,
                       input int n, input int gap, input bit rogue);
        int f0;
        bit data_on;
        for (int i = 7; i >= 0; i--) push(3, 4'b0001, {3'b000, op[i]});
        if (am == 2'd1) for (int i = 23; i >= 0; i--) push(4, 4'b0001, {3'b000, ad[i]});
        if (am == 2'd2) for (int i = 5; i >= 0; i--) push(4, 4'b1111, ad[i*4 +: 4]);
        if (ae) begin
            push(5, 4'b1111, al[7:4]);
            push(5, 4'b1111, al[3:0]);
        end
        for (int i = 0; i < int'(dm); i++) push(6, 4'b0000, 4'b0000);
        data_on = (md == 2'd1 || md == 2'd2) && n > 0;
        if (data_on) begin
            for (int b = 0; b < n; b++) begin
                logic [7:0] v;
                if (wr) begin
                    v = 8'((b * 8'h5B) ^ op ^ 8'h3C);
                    tx_q.push_back(v);
                    if (md == 2'd1) for (int i = 7; i >= 0; i--) push(7, 4'b0001, {3'b000, v[i]});
                    else begin
                        push(7, 4'b1111, v[7:4]);
                        push(7, 4'b1111, v[3:0]);
                    end
                end else begin
                    v = 8'((b * 8'h37) + 8'hC6 + op);
                    rx_exp_q.push_back(v);
                    if (md == 2'd1) begin
                        for (int i = 7; i >= 0; i--) begin
                            drive_arr[exp_q.size()] = {2'b10, v[i], ~v[i]};
                            push(8, 4'b0000, 4'b0000);
                        end
                    end else begin
                        drive_arr[exp_q.size()] = v[7:4];
                        push(8, 4'b0000, 4'b0000);
                        drive_arr[exp_q.size()] = v[3:0];
                        push(8, 4'b0000, 4'b0000);
                    end
                end
            end
        end
        cur_p  = (p == 8'd0) ? 1 : int'(p);
        per_en = !(data_on && wr);
        tx_gap = gap;
        f0     = frames;
        @(negedge clk);
        cmd_opcode = op; cmd_presc = p; cmd_addr_mode = am; cmd_addr = ad;
        cmd_alt_en = ae; cmd_alt = al; cmd_dummy = dm; cmd_data_mode = md;
        cmd_data_write = wr; cmd_nbytes = 16'(n); cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        check("R1 busy after accept", {31'd0, busy}, 32'd1);
        check("R1 cs_n low after accept", {31'd0, cs_n}, 32'd0);
        if (rogue) begin
            repeat (12) @(negedge clk);
            cmd_opcode = 8'h00; cmd_addr_mode = 2'd1; cmd_dummy = 5'd9; cmd_valid = 1'b1;
            @(negedge clk);
            cmd_valid = 1'b0;
        end
        while (busy) @(negedge clk);
        repeat (2) @(negedge clk);
        check("R9 frame cycle count", 32'(exp_q.size()), 32'd0);
        check("R8 read bytes delivered", 32'(rx_exp_q.size()), 32'd0);
        check("R7 write bytes consumed", 32'(tx_q.size()), 32'd0);
        check("R1 one frame per command", 32'(frames - f0), 32'd1);
        exp_q.delete();
        rx_exp_q.delete();
        tx_q.delete();
    endtask

    task automatic finish_up();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        finish_up();
    end

    initial begin
        for (int i = 0; i < 512; i++) drive_arr[i] = 4'h0;
        repeat (3) @(negedge clk);
        // R11 reset state
        check("R11 cs_n", {31'd0, cs_n}, 32'd1);
        check("R11 sclk", {31'd0, sclk}, 32'd0);
        check("R11 io_oe", {28'd0, io_oe}, 32'd0);
        check("R11 busy", {31'd0, busy}, 32'd0);
        check("R11 rx_valid", {31'd0, rx_valid}, 32'd0);
        check("R11 tx_ready", {31'd0, tx_ready}, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R3 R8: single-lane read, no address, divide by 3
        run(8'hA5, 8'd2, 2'd0, 24'h0, 1'b0, 8'h00, 5'd0, 2'd1, 1'b0, 3, 0, 1'b0);
        // R4 R5 R6 R8: quad address, alternate byte, dummy, quad read
        run(8'hEB, 8'd1, 2'd2, 24'h123456, 1'b1, 8'hC3, 5'd4, 2'd2, 1'b0, 4, 0, 1'b0);
        // R4 R7: single-lane address and write with a starving stream
        run(8'h02, 8'd3, 2'd1, 24'hA00F81, 1'b0, 8'h00, 5'd0, 2'd1, 1'b1, 2, 3, 1'b0);
        // R1 R7 R12: quad write with a stray command while busy
        run(8'h38, 8'd1, 2'd2, 24'h7ED219, 1'b0, 8'h00, 5'd2, 2'd2, 1'b1, 5, 0, 1'b1);
        // R2 R9: prescaler 0, instruction only, zero byte count
        run(8'h06, 8'd0, 2'd0, 24'h0, 1'b0, 8'h00, 5'd0, 2'd2, 1'b1, 0, 0, 1'b0);
        // R4 R9: reserved address and data lane codes skip their phases
        run(8'h5A, 8'd4, 2'd3, 24'hFFFFFF, 1'b1, 8'h96, 5'd3, 2'd3, 1'b0, 7, 0, 1'b0);
        // R2: same single-lane read again at a larger prescaler
        run(8'h9C, 8'd4, 2'd1, 24'h00F0F0, 1'b0, 8'h00, 5'd1, 2'd1, 1'b0, 2, 0, 1'b0);
        finish_up();
    end

endmodule